// File: doc/BRIEF.md
# Device Power State Control Register

A 16-bit control/status register that lets host software move a peripheral function between a full-on state and two low-power states. Address decoding happens outside; the block sees a one-cycle write strobe, two byte enables, write data, and returns its current contents on a combinational read-data port.

The stored power state drives the enables for the DMA contexts, the link layer and the link power status signal. In either low-power state a rising edge on the link-on input latches a wake-event status bit. While that status bit and the wake enable bit are both set, the wake request output is asserted. Software clears the status bit by writing a one to it.

Top module: `dev_pwr_ctl`

## Requirements
- R1: After reset the state field (bits 1:0) is 00, the wake enable (bit 8) is 0, the wake status (bit 15) is 0, and rdata_o reads 0x0000.
- R2: A write with be_i[0]=1 loads bits 1:0 from wdata_i[1:0] when the value is 00, 10 or 11. The field reads back on rdata_o[1:0].
- R3: A write of 01 to bits 1:0 leaves the stored state unchanged.
- R4: In state 00, dma_en_o, link_en_o and lps_o are all 1.
- R5: In states 10 and 11, dma_en_o, link_en_o and lps_o are all 0.
- R6: Bit 8 is the wake enable. A write with be_i[0]=1 loads it from wdata_i[8].
- R7: The wake status bit 15 sets on the clock after link_on_i rises while the state is 10 or 11. A rising edge in state 00 does not set it.
- R8: A write with be_i[1]=1 and wdata_i[15]=1 clears the wake status. A write with wdata_i[15]=0 leaves it unchanged.
- R9: If a set and a clear of the wake status fall in the same cycle, the status ends up set.
- R10: pme_o is 1 exactly while wake status and wake enable are both 1. It stays high until the status is cleared.
- R11: Bits 7:2 and 14:9 always read 0, whatever is written to them.
- R12: A byte lane whose enable is 0 is not written. Bits 1:0 and 8 are in lane 0, and bit 15 is in lane 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| be_i | input | 2 | Byte enables, bit 0 for the low byte and bit 1 for the high byte |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Current register contents |
| link_on_i | input | 1 | Link-on indication from the link side |
| dma_en_o | output | 1 | DMA context enable |
| link_en_o | output | 1 | Link layer enable |
| lps_o | output | 1 | Link power status |
| pme_o | output | 1 | Wake event request |

## Verification
The assertions assume that link_on_i is synchronous to clk_i, and that the inputs carry known values from the first clock edge after reset onward. The edge detector and the set-over-clear check both depend on this. The random stimulus drives every input at the falling edge from $urandom with a fixed seed. The link-on level is toggled often enough to produce edges in every state. Writes are biased so that the unsupported state code, clear-one writes and same-cycle set/clear collisions all occur many times.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int DW       = 16;
  localparam int BEW      = DW / 8;
  localparam int SW       = 2;
  localparam int EN_BIT   = 8;
  localparam int STAT_BIT = 15;

  typedef enum logic [SW-1:0] {
    PS_ON   = 2'b00,
    PS_RSVD = 2'b01,
    PS_LOW  = 2'b10,
    PS_OFF  = 2'b11
  } pstate_e;
endpackage

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] wstate_i,
  output pstate_e       state_o,
  output logic          low_pwr_o,
  output logic          dma_en_o,
  output logic          link_en_o,
  output logic          lps_o
);
  pstate_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_ON;
    else if (we_i && (pstate_e'(wstate_i) != PS_RSVD)) state_q <= pstate_e'(wstate_i);
  end

  always_comb begin
    low_pwr_o = (state_q == PS_LOW) || (state_q == PS_OFF);
    dma_en_o  = !low_pwr_o;
    link_en_o = !low_pwr_o;
    lps_o     = !low_pwr_o;
  end

  assign state_o = state_q;

  assert_rsvd_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wstate_i == 2'b01) |=> $stable(state_q));
endmodule

// File: rtl/wake_evt.sv
module wake_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_pwr_i,
  input  logic link_on_i,
  input  logic en_we_i,
  input  logic en_d_i,
  input  logic clr_i,
  output logic en_o,
  output logic stat_o,
  output logic pme_o
);
  logic link_q, en_q, stat_q, set_evt;

  assign set_evt = low_pwr_i && link_on_i && !link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= 1'b0;
      en_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      link_q <= link_on_i;
      if (en_we_i) en_q <= en_d_i;
      // set wins over clear
      if (set_evt)    stat_q <= 1'b1;
      else if (clr_i) stat_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign stat_o = stat_q;
  assign pme_o  = stat_q && en_q;

  assert_set_on_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_pwr_i && link_on_i && !link_q) |=> stat_o);
  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(low_pwr_i && link_on_i && !link_q)) |=> !stat_o);
  assert_stat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o && !clr_i) |=> stat_o);
endmodule

// File: rtl/dev_pwr_ctl.sv
module dev_pwr_ctl
  import pwr_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [BEW-1:0] be_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic           link_on_i,
  output logic           dma_en_o,
  output logic           link_en_o,
  output logic           lps_o,
  output logic           pme_o
);
  logic    lane0_we, lane1_we, low_pwr, en, stat;
  pstate_e state;
  logic    unused_wdata;

  assign lane0_we     = wr_en_i && be_i[0];
  assign lane1_we     = wr_en_i && be_i[1];
  assign unused_wdata = ^{wdata_i[STAT_BIT-1:EN_BIT+1], wdata_i[EN_BIT-1:SW]};

  pwr_state_ctl i_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (lane0_we),
    .wstate_i  (wdata_i[SW-1:0]),
    .state_o   (state),
    .low_pwr_o (low_pwr),
    .dma_en_o  (dma_en_o),
    .link_en_o (link_en_o),
    .lps_o     (lps_o)
  );

  wake_evt i_wake (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .low_pwr_i (low_pwr),
    .link_on_i (link_on_i),
    .en_we_i   (lane0_we),
    .en_d_i    (wdata_i[EN_BIT]),
    .clr_i     (lane1_we && wdata_i[STAT_BIT]),
    .en_o      (en),
    .stat_o    (stat),
    .pme_o     (pme_o)
  );

  always_comb begin
    rdata_o           = '0;
    rdata_o[SW-1:0]   = state;
    rdata_o[EN_BIT]   = en;
    rdata_o[STAT_BIT] = stat;
  end

  assert_lowpwr_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[1] |-> !(dma_en_o || link_en_o || lps_o));
  assert_pme_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pme_o == (rdata_o[STAT_BIT] && rdata_o[EN_BIT]));
  assert_rsvd_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[14:9] == '0 && rdata_o[7:2] == '0);
  assert_never_rsvd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[1:0] != 2'b01);
endmodule

// File: tb/test_dev_pwr_ctl.sv
module test_dev_pwr_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic        link_on = 1'b0;
  logic [15:0] rdata;
  logic        dma_en, link_en, lps, pme;

  int checks = 0;
  int errors = 0;

  logic [1:0] m_state;
  logic       m_en, m_stat, m_lq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dev_pwr_ctl i_dev_pwr_ctl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .be_i(be), .wdata_i(wdata),
    .rdata_o(rdata), .link_on_i(link_on), .dma_en_o(dma_en), .link_en_o(link_en),
    .lps_o(lps), .pme_o(pme)
  );

  function automatic logic [15:0] exp_rdata();
    logic [15:0] r = '0;
    r[1:0] = m_state;
    r[8]   = m_en;
    r[15]  = m_stat;
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic low;
    low = m_state[1];
    chk(req, rdata, exp_rdata());
    chk(low ? "R5" : "R4", {13'b0, dma_en, link_en, lps}, low ? 16'h0 : 16'h7);
    chk("R10", {15'b0, pme}, {15'b0, m_stat && m_en});
  endtask

  // drive at falling edge, update model, check at next falling edge
  task automatic step(input logic w, input logic [1:0] b, input logic [15:0] d,
                      input logic lo, input string req);
    logic set;
    wr_en = w; be = b; wdata = d; link_on = lo;
    set = m_state[1] && lo && !m_lq;
    if (w && b[0]) begin
      if (d[1:0] != 2'b01) m_state = d[1:0];
      m_en = d[8];
    end
    if (set) m_stat = 1'b1;
    else if (w && b[1] && d[15]) m_stat = 1'b0;
    m_lq = lo;
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_state = 2'b00; m_en = 1'b0; m_stat = 1'b0; m_lq = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", rdata, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    step(1, 2'b01, 16'h0002, 0, "R2");        // to 10
    step(1, 2'b01, 16'h0001, 0, "R3");        // 01 dropped
    step(1, 2'b01, 16'h0103, 0, "R6");        // to 11, enable on
    step(0, 2'b00, 16'h0000, 1, "R7");        // rising link-on sets status
    chk("R10", {15'b0, pme}, 16'h1);
    step(0, 2'b00, 16'h0000, 1, "R10");       // held
    step(1, 2'b01, 16'h8103, 1, "R12");       // lane1 off: no clear
    step(1, 2'b10, 16'h0000, 1, "R8");        // write 0 to bit 15: no effect
    step(1, 2'b11, 16'hFFFF, 0, "R11");       // reserved ones ignored, clear, state 11
    chk("R8", {15'b0, rdata[15]}, 16'h0);
    step(1, 2'b10, 16'h8000, 1, "R9");        // set and clear together
    chk("R9", {15'b0, rdata[15]}, 16'h1);
    step(1, 2'b10, 16'h8000, 0, "R8");
    step(1, 2'b01, 16'h0100, 0, "R2");        // back to 00
    step(0, 2'b00, 16'h0000, 1, "R7");        // edge in 00: no set
    chk("R7", {15'b0, rdata[15]}, 16'h0);
    step(1, 2'b10, 16'h0002, 0, "R12");       // lane0 off: state unchanged
    chk("R12", {14'b0, rdata[1:0]}, 16'h0);

    for (int i = 0; i < 3000; i++) begin
      logic w;
      logic [1:0] b;
      logic [15:0] d;
      w = ($urandom_range(0, 2) != 0);
      b = 2'($urandom);
      d = 16'($urandom);
      if ($urandom_range(0, 3) == 0) d[1:0] = 2'b01;
      step(w, b, d, 1'($urandom_range(0, 1)), "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule